// File: doc/BRIEF.md
# Pulsed Byte-Program Sequencer

This block sits on the host side of a command-driven parallel flash device and programs one byte into it. Each attempt runs the same loop. The block writes the setup command, then writes the target address and data. It waits out the program pulse, then writes the program-verify command. After a recovery wait it reads the byte back and compares it with the intended value. A match ends the run with a pass. A mismatch starts another attempt, until a fixed attempt limit is reached, which ends the run with a fail. Every run, pass or fail, finishes by writing the read-mode command.

Requests arrive on a valid/ready port carrying a 17-bit address and a data byte. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. The block applies no back-pressure beyond `req_ready`: a request presented while `req_ready` is low is discarded and is not held for later, so the requester must re-present it once `req_ready` returns. The flash side is a plain synchronous bus with one-cycle write and read strobes. Read data must be on `bus_rdata` in the cycle right after the read strobe. The wait lengths come from a clock rate in MHz and durations in microseconds.

Top module: `pulse_prog_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `bus_wr` and `bus_rd` are low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle `busy` is high and `req_ready` is low (`req_ready` is always the inverse of `busy`), until the cycle in which `done` is high.
- R3: Each attempt begins with a write of data 40h at address 0. In the very next cycle comes a write carrying the accepted address and data byte.
- R4: The verify write (data C0h, address 0) comes exactly PULSE_CYC+1 cycles after the address/data write, where PULSE_CYC = CLK_MHZ*PULSE_US. No bus strobe occurs in between.
- R5: The read strobe, at the accepted address, comes exactly RECOV_CYC+1 cycles after the verify write, where RECOV_CYC = CLK_MHZ*RECOV_US. `bus_rdata` is sampled in the cycle after the read strobe, and no strobe occurs in that cycle.
- R6: If the sampled byte equals the target data, the run ends with `pass` high. Otherwise, while fewer than MAX_PULSES attempts have been made, the next attempt's 40h write follows 2 cycles after the read strobe.
- R7: If the MAX_PULSES-th read-back (default 25) still mismatches, the run ends with `pass` low and `pulse_count` equal to MAX_PULSES.
- R8: Every run ends with a write of data 00h at address 0, 2 cycles after the last read strobe. `done` is high for exactly the next cycle, and no further strobe follows.
- R9: `pulse_count` is 0 the cycle after a request is accepted and counts the address/data writes of the run. While the block is idle, it and `pass` hold their final values until the next acceptance.
- R10: A request presented while `busy` is high is ignored. It does not change the address, data, attempt count or outcome of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 17 | Byte address to program |
| req_data | input | 8 | Byte value to program |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Outcome of the last run (1 = byte verified) |
| pulse_count | output | 5 | Attempts made in the last or current run |
| bus_wr | output | 1 | Flash write strobe |
| bus_rd | output | 1 | Flash read strobe |
| bus_addr | output | 17 | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data, valid the cycle after `bus_rd` |

## Verification
Every result of this block is due at a fixed offset:
- the address/data write, 1 cycle after the 40h write;
- the verify write, PULSE_CYC+1 cycles after the address/data write;
- the read, RECOV_CYC+1 cycles after the verify write;
- the next 40h write or the final 00h write, 2 cycles after the read;
- `done`, 1 cycle after the 00h write;
- `busy` and a cleared count, 1 cycle after acceptance.

The bench keeps a free-running cycle count on the falling edge. It stamps each strobe and compares the exact distance to these figures, so an early or late strobe fails. It also plays the flash. Each run draws a number of attempts after which the read-back matches. From that number the bench predicts the strobe sequence, the outcome and the final count.

// File: rtl/pulse_prog_pkg.sv
package pulse_prog_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_SETUP  = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_VERIFY = 8'hC0;
  localparam logic [BYTE_W-1:0] CMD_READ   = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PROG,
    ST_PULSE,
    ST_VERIFY,
    ST_RECOV,
    ST_READ,
    ST_CMP,
    ST_FINAL,
    ST_REPORT
  } pp_state_e;

endpackage

// File: rtl/pp_wait_timer.sv
module pp_wait_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/pp_pulse_counter.sv
module pp_pulse_counter #(
  parameter int LIMIT = 25,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             incr,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (incr) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count    = count_q;
  assign at_limit = (count_q == CNT_W'(LIMIT));

endmodule

// File: rtl/pp_seq_fsm.sv
module pp_seq_fsm
  import pulse_prog_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int TMR_W     = 9,
  parameter int PULSE_CYC = 500,
  parameter int RECOV_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              pass,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  input  logic              cnt_at_limit,
  output logic              cnt_clear,
  output logic              cnt_incr,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata
);

  pp_state_e         state_q, state_d;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [BYTE_W-1:0] tgt_data_q;
  logic              pass_q;
  logic              accept;
  logic              match;

  assign busy      = (state_q != ST_IDLE) && (state_q != ST_REPORT);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign match     = (bus_rdata == tgt_data_q);
  assign done      = (state_q == ST_REPORT);
  assign pass      = pass_q;
  assign cnt_clear = accept;
  assign cnt_incr  = (state_q == ST_PROG);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_REPORT: begin
        if (accept) state_d = ST_SETUP;
        else        state_d = ST_IDLE;
      end
      ST_SETUP:  state_d = ST_PROG;
      ST_PROG:   state_d = ST_PULSE;
      ST_PULSE:  if (tmr_expired) state_d = ST_VERIFY;
      ST_VERIFY: state_d = ST_RECOV;
      ST_RECOV:  if (tmr_expired) state_d = ST_READ;
      ST_READ:   state_d = ST_CMP;
      ST_CMP: begin
        if (match || cnt_at_limit) state_d = ST_FINAL;
        else                       state_d = ST_SETUP;
      end
      ST_FINAL:  state_d = ST_REPORT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      pass_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tgt_addr_q <= req_addr;
        tgt_data_q <= req_data;
        pass_q     <= 1'b0;
      end else if (state_q == ST_CMP) begin
        pass_q <= match;
      end
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_PROG) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(PULSE_CYC - 1);
    end else if (state_q == ST_VERIFY) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(RECOV_CYC - 1);
    end
  end

  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state_q)
      ST_SETUP: begin
        bus_wr    = 1'b1;
        bus_wdata = CMD_SETUP;
      end
      ST_PROG: begin
        bus_wr    = 1'b1;
        bus_addr  = tgt_addr_q;
        bus_wdata = tgt_data_q;
      end
      ST_VERIFY: begin
        bus_wr    = 1'b1;
        bus_wdata = CMD_VERIFY;
      end
      ST_READ: begin
        bus_rd   = 1'b1;
        bus_addr = tgt_addr_q;
      end
      ST_FINAL: begin
        bus_wr    = 1'b1;
        bus_wdata = CMD_READ;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pulse_prog_ctrl.sv
module pulse_prog_ctrl
  import pulse_prog_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CLK_MHZ    = 50,
  parameter int PULSE_US   = 10,
  parameter int RECOV_US   = 6,
  parameter int MAX_PULSES = 25,
  parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  pulse_count,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int RECOV_CYC = CLK_MHZ * RECOV_US;
  localparam int LONGEST   = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int TMR_W     = $clog2(LONGEST + 1);

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             cnt_clear;
  logic             cnt_incr;
  logic             cnt_at_limit;

  pp_seq_fsm #(
    .ADDR_W    (ADDR_W),
    .TMR_W     (TMR_W),
    .PULSE_CYC (PULSE_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .req_ready    (req_ready),
    .busy         (busy),
    .done         (done),
    .pass         (pass),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .cnt_at_limit (cnt_at_limit),
    .cnt_clear    (cnt_clear),
    .cnt_incr     (cnt_incr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata)
  );

  pp_wait_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pp_pulse_counter #(
    .LIMIT (MAX_PULSES),
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .incr     (cnt_incr),
    .count    (pulse_count),
    .at_limit (cnt_at_limit)
  );

endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int ADDR_W     = 17,
  parameter int CNT_W      = 5,
  parameter int MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  pulse_count,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata
);

  // R2
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && pulse_count == '0));

  // R10
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R3
  setup_then_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$past(bus_wr) && bus_wdata == 8'h40) |=> bus_wr);

  // R3
  setup_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$past(bus_wr) && bus_wdata == 8'h40) |-> (bus_addr == '0));

  // R5
  verify_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$past(bus_wr) && bus_wdata == 8'hC0) |=> (!bus_rd && !bus_wr));

  // R5
  read_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (!bus_rd && !bus_wr));

  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R8
  done_after_reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_wr) && $past(bus_wdata) == 8'h00 && !busy));

  // R7
  count_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pulse_count != '0 && pulse_count <= CNT_W'(MAX_PULSES)));

  // R9
  count_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(req_valid && req_ready)) |-> $stable(pulse_count));

endmodule

bind pulse_prog_ctrl pp_checker #(
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W),
  .MAX_PULSES (MAX_PULSES)
) u_pp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .pulse_count (pulse_count),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata)
);

// File: tb/pulse_prog_ctrl_bench.sv
module pulse_prog_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 17;
  localparam int CLK_MHZ    = 2;
  localparam int PULSE_US   = 10;
  localparam int RECOV_US   = 6;
  localparam int MAX_P      = 25;
  localparam int CNT_W      = $clog2(MAX_P + 1);
  localparam int PULSE_CYC  = CLK_MHZ * PULSE_US;
  localparam int RECOV_CYC  = CLK_MHZ * RECOV_US;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0]        req_data = '0;
  logic              busy, done, pass;
  logic [CNT_W-1:0]  pulse_count;
  logic              bus_wr, bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata;
  logic [7:0]        bus_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_prog_ctrl #(
    .ADDR_W     (ADDR_W),
    .CLK_MHZ    (CLK_MHZ),
    .PULSE_US   (PULSE_US),
    .RECOV_US   (RECOV_US),
    .MAX_PULSES (MAX_P)
  ) u_pulse_prog_ctrl (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_data (req_data),
    .busy (busy), .done (done), .pass (pass), .pulse_count (pulse_count),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_pass(input int need);
    return need <= MAX_P;
  endfunction

  function automatic int exp_count(input int need);
    return (need <= MAX_P) ? need : MAX_P;
  endfunction

  // flash model and bus monitor state
  int              cyc = 0;
  int              ph = 6;
  int              need = 1;
  int              seen = 0;
  int              t_last, t_prog, t_ver, t_rd, t_fin;
  logic [ADDR_W-1:0] tgt_a;
  logic [7:0]      tgt_d;
  bit              run_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (bus_wr || bus_rd) begin
        case (ph)
          0: begin
            chk(bus_wr && bus_wdata == 8'h40 && bus_addr == '0, "R3 setup write", bus_wdata, 8'h40);
            t_last = cyc; ph = 1;
          end
          1: begin
            chk(bus_wr && bus_addr == tgt_a, "R3 program address", bus_addr, tgt_a);
            chk(bus_wdata == tgt_d && cyc == t_last + 1, "R3 program data/timing", bus_wdata, tgt_d);
            seen++; t_prog = cyc; ph = 2;
          end
          2: begin
            chk(bus_wr && bus_wdata == 8'hC0 && bus_addr == '0, "R4 verify write", bus_wdata, 8'hC0);
            chk(cyc == t_prog + PULSE_CYC + 1, "R4 pulse wait", cyc - t_prog, PULSE_CYC + 1);
            t_ver = cyc; ph = 3;
          end
          3: begin
            chk(bus_rd && bus_addr == tgt_a, "R5 read address", bus_addr, tgt_a);
            chk(cyc == t_ver + RECOV_CYC + 1, "R5 recovery wait", cyc - t_ver, RECOV_CYC + 1);
            bus_rdata = (seen >= need) ? tgt_d : (tgt_d ^ 8'h3C);
            t_rd = cyc; ph = 4;
          end
          4: begin
            if (bus_wr && bus_wdata == 8'h40) begin
              chk(seen < need && seen < MAX_P, "R6 retry allowed", seen, need);
              chk(cyc == t_rd + 2, "R6 retry timing", cyc - t_rd, 2);
              t_last = cyc; ph = 1;
            end else begin
              chk(bus_wr && bus_wdata == 8'h00 && bus_addr == '0, "R8 final write", bus_wdata, 0);
              chk(seen >= need || seen == MAX_P, "R7 stop point", seen, exp_count(need));
              chk(cyc == t_rd + 2, "R8 final timing", cyc - t_rd, 2);
              t_fin = cyc; ph = 5;
            end
          end
          default: chk(1'b0, "R8 strobe after end", ph, 0);
        endcase
      end
      if (done) begin
        chk(ph == 5 && cyc == t_fin + 1, "R8 done timing", cyc - t_fin, 1);
        chk(pass == exp_pass(need), "R6 R7 pass flag", pass, exp_pass(need));
        chk(int'(pulse_count) == exp_count(need), "R9 final count", pulse_count, exp_count(need));
        run_done = 1;
      end
    end
  end

  task automatic run_one(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input int n, input bit poke);
    int waited;
    logic [CNT_W-1:0] held;
    @(negedge clk);
    need = n; seen = 0; ph = 0; run_done = 0; tgt_a = a; tgt_d = d;
    chk(req_ready && !busy, "R2 ready before start", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2 busy after accept", busy, 1);
    chk(pulse_count == '0, "R9 count cleared", pulse_count, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_addr = a ^ 17'h1; req_data = ~d;
      repeat (3) begin
        @(negedge clk);
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    waited = 0;
    while (!run_done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (!run_done) chk(1'b0, "R8 run timeout", waited, 3000);
    held = pulse_count;
    repeat (5) @(negedge clk);
    chk(pulse_count == held && pass == exp_pass(n), "R9 hold after done", pulse_count, held);
    chk(!busy && req_ready, "R2 idle after done", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_wr && !bus_rd, "R1 reset outputs", busy, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    // directed corners
    run_one(17'h00000, 8'hA5, 1, 0);
    run_one(17'h1FFFF, 8'h00, 2, 1);
    run_one(17'h12345, 8'h40, MAX_P, 0);
    run_one(17'h0C0C0, 8'hC0, MAX_P + 1, 0);
    run_one(17'h00001, 8'hFF, 40, 1);
    // random runs
    for (int i = 0; i < 16; i++) begin
      run_one(ADDR_W'($urandom), 8'($urandom), 1 + ($urandom % 30), ($urandom % 2) == 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule